// File: doc/BRIEF.md
# Event-Count Prescaler with Interrupt Gating

This block sits behind a PWM time base and divides down its qualified trigger events. One interrupt channel and a parameterised number of conversion-start channels (two by default) each count their own event strobe. When a channel's count reaches its programmed period of one to three events, the channel emits a one-cycle pulse and its count returns to zero. Each channel has a 2-bit period register that software can write and read back, and a 2-bit event count that software can read.

Every pulse also sets a latched status flag. Software clears these flags with write-one-to-clear strobes. The interrupt channel respects its flag: while an earlier interrupt is still pending, no new interrupt is issued and the count parks at the period value. The conversion channels ignore their flags and keep firing. Software can also force an interrupt directly.

Top module: `evtrig_prescaler`

## Requirements
- R1: A channel whose period register holds 00 emits no pulse. Outside a period write, its count holds its value. A period write with an event in the same cycle still increments the count (see R8).
- R2: With period P of 1, 2 or 3, a channel that is permitted to fire pulses on the event that brings its count to P. In that same clock step the count returns to 0.
- R3: The count output of each channel shows the number of events accepted since that channel's last pulse.
- R4: A channel that is not permitted to fire keeps counting events up to P and then holds at P. For the interrupt channel this means its enable is 0 or its flag is set. For a conversion channel it means its enable is 0.
- R5: A channel that is parked at P fires in the first cycle in which it becomes permitted, with no new event needed.
- R6: A conversion channel fires even while its own flag is still set.
- R7: Writing a period equal to the current count fires the channel in that cycle, if the channel is permitted to fire.
- R8: An event in the same cycle as a period write still increments the count. A written period lower than the current count first resets the count to 0, and the event is then added to that 0.
- R9: A force strobe on the interrupt channel fires it at once and clears its count, provided the period is not 00, the enable is 1 and the flag is clear. With period 00 the force is ignored.
- R10: Flags reset to 0 and are laid out as follows: bit 0 is the interrupt flag and bit 2+i is the flag of conversion channel i. All other bits read 0. A flag becomes 1 in the same clock step as its channel's pulse.
- R11: The clear strobes are write-one-to-clear. When a set and a clear meet in the same cycle, the set wins.
- R12: Every pulse lasts one clock cycle. Reset zeroes all counts, periods, flags and pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_evt | input | 1 | Interrupt-channel event strobe |
| irq_en | input | 1 | Interrupt enable |
| irq_prd_we | input | 1 | Interrupt period write strobe |
| irq_prd_wdata | input | CW | Interrupt period write value |
| irq_force | input | 1 | Software force of an interrupt |
| irq_clr | input | 1 | Write-one-to-clear for the interrupt flag |
| soc_evt | input | NS | Conversion-channel event strobes |
| soc_en | input | NS | Conversion-channel enables |
| soc_prd_we | input | NS | Conversion period write strobes |
| soc_prd_wdata | input | NS*CW | Conversion period write values, channel i at [i*CW +: CW] |
| soc_clr | input | NS | Write-one-to-clear for the conversion flags |
| irq_pulse | output | 1 | One-cycle interrupt request |
| soc_pulse | output | NS | One-cycle conversion-start pulses |
| irq_cnt | output | CW | Interrupt event count |
| irq_prd | output | CW | Interrupt period readback |
| soc_cnt | output | NS*CW | Conversion event counts |
| soc_prd | output | NS*CW | Conversion period readbacks |
| flags | output | FW | Latched status flags |

## Verification
On every cycle the checker confirms four things. A pulse always arrives with its flag set and its count at zero. An interrupt pulse never appears with a zero period or follows an enable of 0 or a set flag. A clear without a coincident pulse leaves the flag at 0. Behaviours that depend on a history of events are shown only by the bench's scenarios: saturation at the period, release of a parked count once the flag is cleared, the equal-period and lower-period writes, forced interrupts, and conversion channels firing through a set flag.

// File: rtl/evtp_pkg.sv
package evtp_pkg;
   localparam int IRQ_FLAG_POS  = 0;
   localparam int SOC_FLAG_BASE = 2;

   typedef enum logic {
      CH_FREE  = 1'b0,
      CH_GATED = 1'b1
   } ch_kind_e;
endpackage

// File: rtl/evtp_chan.sv
module evtp_chan
   import evtp_pkg::*;
#(
   parameter int       CW   = 2,
   parameter ch_kind_e KIND = CH_FREE
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          evt,
   input  logic          en,
   input  logic          flag_i,
   input  logic          force_i,
   input  logic          prd_we,
   input  logic [CW-1:0] prd_wdata,
   output logic          fire_o,
   output logic          pulse_o,
   output logic [CW-1:0] cnt_o,
   output logic [CW-1:0] prd_o
);
   localparam logic [CW:0] ONE_W = (CW+1)'(1);

   generate
      if (CW < 1) begin : g_bad_cw
         $error("evtp_chan: CW must be at least 1");
      end
   endgenerate

   logic [CW-1:0] cnt_q, prd_q, p_eff, base, cnt_d;
   logic [CW:0]   cand;
   logic          hold, frc, allow, hit;

   generate
      if (KIND == CH_GATED) begin : g_gated
         assign hold = flag_i;
         assign frc  = force_i;
      end else begin : g_free
         logic unused_ok;
         assign unused_ok = flag_i ^ force_i;
         assign hold = 1'b0;
         assign frc  = 1'b0;
      end
   endgenerate

   always_comb begin
      p_eff = prd_we ? prd_wdata : prd_q;
      base  = (prd_we && (prd_wdata < cnt_q)) ? '0 : cnt_q;
      if (prd_we)
         cand = {1'b0, base} + {{CW{1'b0}}, evt};
      else if (p_eff == '0)
         cand = {1'b0, cnt_q};
      else if (evt && (cnt_q < p_eff))
         cand = {1'b0, cnt_q} + ONE_W;
      else
         cand = {1'b0, cnt_q};
      allow  = en && !hold && (p_eff != '0);
      hit    = allow && (cand >= {1'b0, p_eff});
      fire_o = hit || (allow && frc);
      if (fire_o)
         cnt_d = '0;
      else if ((p_eff != '0) && (cand > {1'b0, p_eff}))
         cnt_d = p_eff;
      else
         cnt_d = cand[CW-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         prd_q   <= '0;
         pulse_o <= 1'b0;
      end else begin
         cnt_q   <= cnt_d;
         prd_q   <= p_eff;
         pulse_o <= fire_o;
      end
   end

   assign cnt_o = cnt_q;
   assign prd_o = prd_q;
endmodule

// File: rtl/evtp_flags.sv
module evtp_flags
   import evtp_pkg::*;
#(
   parameter int NS = 2,
   parameter int FW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          irq_set,
   input  logic          irq_clr,
   input  logic [NS-1:0] soc_set,
   input  logic [NS-1:0] soc_clr,
   output logic [FW-1:0] flags_o
);
   generate
      if (FW < SOC_FLAG_BASE + NS) begin : g_bad_fw
         $error("evtp_flags: FW too narrow for NS channels");
      end
   endgenerate

   logic [NS:0] set_v, clr_v, fl_q;
   assign set_v = {soc_set, irq_set};
   assign clr_v = {soc_clr, irq_clr};

   generate
      for (genvar b = 0; b <= NS; b++) begin : g_bit
         always_ff @(posedge clk) begin
            if (!rst_n)
               fl_q[b] <= 1'b0;
            else if (set_v[b])
               fl_q[b] <= 1'b1;
            else if (clr_v[b])
               fl_q[b] <= 1'b0;
         end
      end
   endgenerate

   always_comb begin
      flags_o = '0;
      flags_o[IRQ_FLAG_POS] = fl_q[0];
      for (int i = 0; i < NS; i++)
         flags_o[SOC_FLAG_BASE+i] = fl_q[i+1];
   end
endmodule

// File: rtl/evtrig_prescaler.sv
module evtrig_prescaler
   import evtp_pkg::*;
#(
   parameter int CW = 2,
   parameter int NS = 2,
   parameter int FW = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             irq_evt,
   input  logic             irq_en,
   input  logic             irq_prd_we,
   input  logic [CW-1:0]    irq_prd_wdata,
   input  logic             irq_force,
   input  logic             irq_clr,
   input  logic [NS-1:0]    soc_evt,
   input  logic [NS-1:0]    soc_en,
   input  logic [NS-1:0]    soc_prd_we,
   input  logic [NS*CW-1:0] soc_prd_wdata,
   input  logic [NS-1:0]    soc_clr,
   output logic             irq_pulse,
   output logic [NS-1:0]    soc_pulse,
   output logic [CW-1:0]    irq_cnt,
   output logic [CW-1:0]    irq_prd,
   output logic [NS*CW-1:0] soc_cnt,
   output logic [NS*CW-1:0] soc_prd,
   output logic [FW-1:0]    flags
);
   generate
      if (NS < 1) begin : g_bad_ns
         $error("evtrig_prescaler: NS must be at least 1");
      end
   endgenerate

   logic          irq_fire;
   logic [NS-1:0] soc_fire;

   evtp_chan #(.CW(CW), .KIND(CH_GATED)) u_irq_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .evt       (irq_evt),
      .en        (irq_en),
      .flag_i    (flags[IRQ_FLAG_POS]),
      .force_i   (irq_force),
      .prd_we    (irq_prd_we),
      .prd_wdata (irq_prd_wdata),
      .fire_o    (irq_fire),
      .pulse_o   (irq_pulse),
      .cnt_o     (irq_cnt),
      .prd_o     (irq_prd)
   );

   generate
      for (genvar c = 0; c < NS; c++) begin : g_soc
         evtp_chan #(.CW(CW), .KIND(CH_FREE)) u_soc_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .evt       (soc_evt[c]),
            .en        (soc_en[c]),
            .flag_i    (flags[SOC_FLAG_BASE+c]),
            .force_i   (1'b0),
            .prd_we    (soc_prd_we[c]),
            .prd_wdata (soc_prd_wdata[c*CW +: CW]),
            .fire_o    (soc_fire[c]),
            .pulse_o   (soc_pulse[c]),
            .cnt_o     (soc_cnt[c*CW +: CW]),
            .prd_o     (soc_prd[c*CW +: CW])
         );
      end
   endgenerate

   evtp_flags #(.NS(NS), .FW(FW)) u_flags (
      .clk     (clk),
      .rst_n   (rst_n),
      .irq_set (irq_fire),
      .irq_clr (irq_clr),
      .soc_set (soc_fire),
      .soc_clr (soc_clr),
      .flags_o (flags)
   );
endmodule

// File: rtl/evtrig_prescaler_chk.sv
module evtrig_prescaler_chk
   import evtp_pkg::*;
#(
   parameter int CW = 2,
   parameter int NS = 2,
   parameter int FW = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             irq_en,
   input logic             irq_clr,
   input logic             irq_pulse,
   input logic [CW-1:0]    irq_cnt,
   input logic [CW-1:0]    irq_prd,
   input logic [NS-1:0]    soc_pulse,
   input logic [NS*CW-1:0] soc_cnt,
   input logic [FW-1:0]    flags
);
   p_irq_zero_prd_r1: assert property (@(posedge clk) disable iff (!rst_n)
      irq_pulse |-> (irq_prd != '0));

   p_irq_cnt_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
      irq_pulse |-> (irq_cnt == '0));

   p_irq_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
      irq_pulse |-> ($past(irq_en) && !$past(flags[IRQ_FLAG_POS])));

   p_irq_flag_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
      irq_pulse |-> flags[IRQ_FLAG_POS]);

   p_reserved_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      flags[1] == 1'b0);

   p_irq_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(irq_clr) && !irq_pulse) |-> !flags[IRQ_FLAG_POS]);

   p_irq_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
      irq_pulse |=> !irq_pulse);

   generate
      for (genvar c = 0; c < NS; c++) begin : g_soc_chk
         p_soc_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
            soc_pulse[c] |-> flags[SOC_FLAG_BASE+c]);
         p_soc_cnt_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
            soc_pulse[c] |-> (soc_cnt[c*CW +: CW] == '0));
      end
   endgenerate
endmodule

bind evtrig_prescaler evtrig_prescaler_chk #(.CW(CW), .NS(NS), .FW(FW)) u_chk (.*);

// File: tb/evtrig_prescaler_tb.sv
`timescale 1ns/1ps
module evtrig_prescaler_tb;
   localparam int CW = 2;
   localparam int NS = 2;
   localparam int FW = 8;

   typedef struct packed {
      logic       evt;
      logic       en;
      logic       we;
      logic [1:0] wd;
      logic       frc;
      logic       clr;
      logic       ep;
      logic [1:0] ec;
      logic       ef;
      logic [3:0] rq;
   } vec_t;

   // columns: evt en we wd frc clr | expected pulse cnt flag | requirement
   localparam int NV = 28;
   localparam vec_t VEC [NV] = '{
      '{1'b0,1'b1,1'b1,2'd2,1'b0,1'b0, 1'b0,2'd0,1'b0, 4'd8 },  // R8 write, no event
      '{1'b1,1'b1,1'b0,2'd0,1'b0,1'b0, 1'b0,2'd1,1'b0, 4'd3 },  // R3
      '{1'b1,1'b1,1'b0,2'd0,1'b0,1'b0, 1'b1,2'd0,1'b1, 4'd2 },  // R2 second event fires
      '{1'b0,1'b1,1'b0,2'd0,1'b0,1'b0, 1'b0,2'd0,1'b1, 4'd12},  // R12 single cycle
      '{1'b1,1'b1,1'b0,2'd0,1'b0,1'b0, 1'b0,2'd1,1'b1, 4'd4 },  // R4 flag blocks
      '{1'b1,1'b1,1'b0,2'd0,1'b0,1'b0, 1'b0,2'd2,1'b1, 4'd4 },
      '{1'b1,1'b1,1'b0,2'd0,1'b0,1'b0, 1'b0,2'd2,1'b1, 4'd4 },  // R4 holds at period
      '{1'b0,1'b1,1'b0,2'd0,1'b0,1'b1, 1'b0,2'd2,1'b0, 4'd11},  // R11 clear
      '{1'b0,1'b1,1'b0,2'd0,1'b0,1'b0, 1'b1,2'd0,1'b1, 4'd5 },  // R5 release
      '{1'b0,1'b1,1'b0,2'd0,1'b0,1'b1, 1'b0,2'd0,1'b0, 4'd11},
      '{1'b1,1'b0,1'b0,2'd0,1'b0,1'b0, 1'b0,2'd1,1'b0, 4'd4 },  // R4 disabled
      '{1'b1,1'b0,1'b0,2'd0,1'b0,1'b0, 1'b0,2'd2,1'b0, 4'd4 },
      '{1'b1,1'b0,1'b0,2'd0,1'b0,1'b0, 1'b0,2'd2,1'b0, 4'd4 },
      '{1'b0,1'b1,1'b0,2'd0,1'b0,1'b0, 1'b1,2'd0,1'b1, 4'd5 },  // R5 enable lifts
      '{1'b1,1'b1,1'b0,2'd0,1'b0,1'b1, 1'b0,2'd1,1'b0, 4'd4 },
      '{1'b0,1'b1,1'b1,2'd1,1'b0,1'b0, 1'b1,2'd0,1'b1, 4'd7 },  // R7 equal write
      '{1'b1,1'b1,1'b0,2'd0,1'b0,1'b1, 1'b0,2'd1,1'b0, 4'd4 },
      '{1'b1,1'b1,1'b0,2'd0,1'b0,1'b1, 1'b1,2'd0,1'b1, 4'd11},  // R11 set wins
      '{1'b0,1'b1,1'b0,2'd0,1'b0,1'b1, 1'b0,2'd0,1'b0, 4'd11},
      '{1'b1,1'b1,1'b1,2'd3,1'b0,1'b0, 1'b0,2'd1,1'b0, 4'd8 },  // R8 write + event
      '{1'b1,1'b1,1'b0,2'd0,1'b0,1'b0, 1'b0,2'd2,1'b0, 4'd3 },
      '{1'b0,1'b1,1'b1,2'd1,1'b0,1'b0, 1'b0,2'd0,1'b0, 4'd8 },  // R8 lower write resets
      '{1'b1,1'b1,1'b1,2'd0,1'b0,1'b0, 1'b0,2'd1,1'b0, 4'd8 },  // R8 zero write + event
      '{1'b1,1'b1,1'b0,2'd0,1'b0,1'b0, 1'b0,2'd1,1'b0, 4'd1 },  // R1 disabled counter
      '{1'b0,1'b1,1'b0,2'd0,1'b1,1'b0, 1'b0,2'd1,1'b0, 4'd9 },  // R9 force ignored
      '{1'b0,1'b1,1'b1,2'd3,1'b0,1'b0, 1'b0,2'd1,1'b0, 4'd8 },
      '{1'b0,1'b1,1'b0,2'd0,1'b1,1'b0, 1'b1,2'd0,1'b1, 4'd9 },  // R9 force fires
      '{1'b0,1'b1,1'b0,2'd0,1'b0,1'b1, 1'b0,2'd0,1'b0, 4'd11}
   };

   logic             clk = 1'b0;
   logic             rst_n;
   logic             irq_evt, irq_en, irq_prd_we, irq_force, irq_clr;
   logic [CW-1:0]    irq_prd_wdata;
   logic [NS-1:0]    soc_evt, soc_en, soc_prd_we, soc_clr;
   logic [NS*CW-1:0] soc_prd_wdata;
   logic             irq_pulse;
   logic [NS-1:0]    soc_pulse;
   logic [CW-1:0]    irq_cnt, irq_prd;
   logic [NS*CW-1:0] soc_cnt, soc_prd;
   logic [FW-1:0]    flags;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #2.5 clk = ~clk;

   evtrig_prescaler #(.CW(CW), .NS(NS), .FW(FW)) u_dut (.*);

   task automatic check(input string req, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic idle();
      irq_evt = 1'b0; irq_en = 1'b0; irq_prd_we = 1'b0; irq_force = 1'b0;
      irq_clr = 1'b0; irq_prd_wdata = '0;
      soc_evt = '0; soc_en = '0; soc_prd_we = '0; soc_clr = '0; soc_prd_wdata = '0;
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
      irq_evt = 1'b0; irq_prd_we = 1'b0; irq_force = 1'b0; irq_clr = 1'b0;
      soc_evt = '0; soc_prd_we = '0; soc_clr = '0;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      idle();
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual 0 expected 1");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      do_reset();
      // R12: reset state
      check("R12 irq_cnt", int'(irq_cnt), 0);
      check("R12 irq_prd", int'(irq_prd), 0);
      check("R12 flags", int'(flags), 0);
      check("R12 pulses", int'({irq_pulse, soc_pulse}), 0);

      for (int v = 0; v < NV; v++) begin
         irq_evt = VEC[v].evt; irq_en = VEC[v].en; irq_prd_we = VEC[v].we;
         irq_prd_wdata = VEC[v].wd; irq_force = VEC[v].frc; irq_clr = VEC[v].clr;
         step();
         if (irq_pulse !== VEC[v].ep || irq_cnt !== VEC[v].ec || flags[0] !== VEC[v].ef) begin
            n_fail++;
            $display("FAIL R%0d vector %0d: actual p%0d c%0d f%0d expected p%0d c%0d f%0d",
                     VEC[v].rq, v, irq_pulse, irq_cnt, flags[0], VEC[v].ep, VEC[v].ec, VEC[v].ef);
         end
         n_tests++;
      end
      check("R1 period readback", int'(irq_prd), 3);

      // conversion channel 0: period 3
      do_reset();
      soc_en = 2'b11;
      soc_prd_we[0] = 1'b1; soc_prd_wdata[1:0] = 2'd3;
      step();
      check("R1 soc0 period readback", int'(soc_prd[1:0]), 3);
      soc_evt[0] = 1'b1; step();
      check("R3 soc0 count 1", int'(soc_cnt[1:0]), 1);
      soc_evt[0] = 1'b1; step();
      check("R3 soc0 count 2", int'(soc_cnt[1:0]), 2);
      check("R2 soc0 no early pulse", int'(soc_pulse[0]), 0);
      soc_evt[0] = 1'b1; step();
      check("R2 soc0 third event pulse", int'(soc_pulse[0]), 1);
      check("R2 soc0 count cleared", int'(soc_cnt[1:0]), 0);
      check("R10 soc0 flag bit2", int'(flags[2]), 1);
      check("R10 other bits zero", int'({flags[7:3], flags[1:0]}), 0);
      step();
      check("R12 soc0 pulse one cycle", int'(soc_pulse[0]), 0);
      soc_evt[0] = 1'b1; step();
      soc_evt[0] = 1'b1; step();
      soc_evt[0] = 1'b1; step();
      check("R6 soc0 fires with flag set", int'(soc_pulse[0]), 1);

      // conversion channel 1: period 1, set vs clear
      soc_prd_we[1] = 1'b1; soc_prd_wdata[3:2] = 2'd1; soc_evt[1] = 1'b1;
      step();
      check("R7 soc1 write equal with event", int'(soc_pulse[1]), 1);
      check("R10 soc1 flag bit3", int'(flags[3]), 1);
      soc_evt[1] = 1'b1; soc_clr[1] = 1'b1; step();
      check("R11 soc1 set beats clear", int'(flags[3]), 1);
      check("R6 soc1 back-to-back", int'(soc_pulse[1]), 1);
      soc_clr[1] = 1'b1; step();
      check("R11 soc1 cleared", int'(flags[3]), 0);
      check("R11 soc0 flag untouched", int'(flags[2]), 1);

      // conversion channel 0 disabled: saturates at period
      soc_en[0] = 1'b0;
      for (int k = 0; k < 4; k++) begin
         soc_evt[0] = 1'b1; step();
         check("R4 soc0 disabled no pulse", int'(soc_pulse[0]), 0);
      end
      check("R4 soc0 held at period", int'(soc_cnt[1:0]), 3);
      soc_en[0] = 1'b1; step();
      check("R5 soc0 fires on enable", int'(soc_pulse[0]), 1);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule